// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches four external interrupt pins and turns a valid edge on any of them into a request pulse one clock wide. An 8-bit mode register on a small CPU bus chooses the active edge for three of the pins. Each of those pins can detect falling edges, rising edges, or both. The fourth pin has no setting and always responds to falling edges. Each pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with its level one cycle earlier.

Pin 0 also serves as the count input of a timer. The same register field sets the active edge for the interrupt and for the timer count pulse. The timer path has its own copy of that field. A small state machine updates this copy only while the timer is stopped. It has two states. In `TC_IDLE` the copy matches the register. `TC_PEND` means the copy is out of date. The transitions are:
- idle-to-pend: a write arrives while the timer runs.
- pend-to-idle: the timer-running input goes low, or a write arrives while the timer is stopped.

The pin 0 interrupt itself uses a new setting immediately. Priority, masking, vectoring and the timer itself belong to other blocks.

Top module: `xint_edge_unit`

## Requirements
- R1: The mode register sits at bus address 0xFFEC. A write there with `bus_wr` high stores bits 7:2. `bus_rdata` shows the register (combinationally) while `bus_addr` is 0xFFEC and shows 0 at any other address. Writes to other addresses change nothing.
- R2: After reset the register reads 0x00, so every configurable pin detects falling edges.
- R3: Register bits 1:0 always read 0, whatever was written to them.
- R4: Each configurable pin i (0..2) uses a 2-bit code at register bits [2i+3:2i+2]: 00 detects falling edges, 01 detects rising edges, and 11 detects both. A pin level that changes between clock edges k-1 and k produces a one-cycle pulse on `irq_req[i]` after edge k+2. Each separate transition in both-edges mode gives its own pulse.
- R5: When a pin's code is 10, that pin raises no request.
- R6: Pin 3 has no code and pulses `irq_req[3]` on falling edges only.
- R7: `tmr_cnt_pulse` follows the same timing as R4 for pin 0, but uses the timer copy of bits 3:2. It pulses only if `tmr_run` is high at the edge that registers the pulse.
- R8: A write to 0xFFEC while `tmr_run` is high leaves the timer copy unchanged. The copy takes the register's bits 3:2 at the first clock edge where `tmr_run` is low. A write while `tmr_run` is low updates the copy at once.
- R9: The synchroniser and history flops reset to 1, so pins held high through reset produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 4 | Asynchronous interrupt pins; bit 0 is shared with the timer count input |
| tmr_run | input | 1 | High while the timer is counting |
| irq_req | output | 4 | One-cycle request pulse per pin |
| tmr_cnt_pulse | output | 1 | One-cycle timer count pulse |

## Verification
The hardest overlap is a register write to bits 3:2 in the same cycle that pin 0 produces an edge while `tmr_run` is high. In that cycle the interrupt path switches to the new code but the timer path keeps the old one. The bench provokes this with random writes, pin toggles and timer-running changes on every cycle. Directed sequences also write while the timer runs and then stop it. Every cycle the bench compares `irq_req` and `tmr_cnt_pulse` against a model. The model keeps the interrupt code and the deferred timer code as separate values.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;

    typedef enum logic {
        TC_IDLE = 1'b0,
        TC_PEND = 1'b1
    } tc_state_e;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int          WIDTH   = 4,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] lvl_cur,
    output logic [WIDTH-1:0] lvl_prev
);
    localparam logic [WIDTH-1:0] INIT = {WIDTH{RST_VAL}};

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= INIT;
            lvl_cur  <= INIT;
            lvl_prev <= INIT;
        end else begin
            meta_q   <= raw_in;
            lvl_cur  <= meta_q;
            lvl_prev <= lvl_cur;
        end
    end
endmodule

// File: rtl/xint_edge_det.sv
module xint_edge_det
    import xint_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  edge_code_e code,
    output logic       hit
);
    logic rise, fall;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        unique case (code)
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            EDGE_BOTH: hit = rise | fall;
            EDGE_RSVD: hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/xint_mode_reg.sv
module xint_mode_reg
    import xint_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFEC,
    parameter int                LOW_ZERO  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tmr_run,
    output logic [DATA_W-1:0] mode_q,
    output edge_code_e        tcode_q,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int TC_LSB = LOW_ZERO;
    localparam int TC_MSB = LOW_ZERO + 1;

    logic       sel;
    logic       wr_hit;
    tc_state_e  state_q, state_d;
    edge_code_e tcode_d;

    assign sel       = (bus_addr == MODE_ADDR);
    assign wr_hit    = sel & bus_wr;
    assign bus_rdata = sel ? mode_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_hit) begin
            mode_q <= {bus_wdata[DATA_W-1:LOW_ZERO], {LOW_ZERO{1'b0}}};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TC_IDLE;
            tcode_q <= EDGE_FALL;
        end else begin
            state_q <= state_d;
            tcode_q <= tcode_d;
        end
    end

    // next state and timer-copy outputs
    always_comb begin
        state_d = state_q;
        tcode_d = tcode_q;
        unique case (state_q)
            TC_IDLE: begin
                if (wr_hit) begin
                    if (!tmr_run) tcode_d = edge_code_e'(bus_wdata[TC_MSB:TC_LSB]);
                    else          state_d = TC_PEND;
                end
            end
            TC_PEND: begin
                if (!tmr_run) begin
                    state_d = TC_IDLE;
                    if (wr_hit) tcode_d = edge_code_e'(bus_wdata[TC_MSB:TC_LSB]);
                    else        tcode_d = edge_code_e'(mode_q[TC_MSB:TC_LSB]);
                end
            end
            default: state_d = TC_IDLE;
        endcase
    end
endmodule

// File: rtl/xint_edge_unit.sv
module xint_edge_unit
    import xint_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                NUM_PINS  = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic              tmr_run,
    output logic [NUM_PINS-1:0] irq_req,
    output logic              tmr_cnt_pulse
);
    localparam int CFG_PINS = NUM_PINS - 1;
    localparam int LOW_ZERO = 2;

    logic [DATA_W-1:0]   mode_q;
    edge_code_e          tcode_q;
    logic [NUM_PINS-1:0] sync_cur, sync_prev, hit_w;
    edge_code_e          code_w [NUM_PINS];
    logic                thit_w;

    xint_mode_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR), .LOW_ZERO(LOW_ZERO)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .tmr_run(tmr_run), .mode_q(mode_q),
        .tcode_q(tcode_q), .bus_rdata(bus_rdata)
    );

    xint_sync #(.WIDTH(NUM_PINS), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
        .lvl_cur(sync_cur), .lvl_prev(sync_prev)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i < CFG_PINS) begin : g_cfg
            assign code_w[i] = edge_code_e'(mode_q[2*i+LOW_ZERO+1 -: 2]);
        end else begin : g_fix
            assign code_w[i] = EDGE_FALL;
        end
        xint_edge_det u_det (
            .cur(sync_cur[i]), .prev(sync_prev[i]), .code(code_w[i]), .hit(hit_w[i])
        );
    end

    xint_edge_det u_tdet (
        .cur(sync_cur[0]), .prev(sync_prev[0]), .code(tcode_q), .hit(thit_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req       <= '0;
            tmr_cnt_pulse <= 1'b0;
        end else begin
            irq_req       <= hit_w;
            tmr_cnt_pulse <= thit_w & tmr_run;
        end
    end
endmodule

// File: rtl/xint_edge_chk.sv
module xint_edge_chk
    import xint_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_rdata,
    input logic [3:0] irq_req,
    input logic       tmr_run,
    input logic       tmr_cnt_pulse,
    input logic [7:0] mode_q,
    input edge_code_e tcode_q,
    input logic [3:0] sync_cur,
    input logic [3:0] sync_prev
);
    assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[1:0] == 2'b00);

    assert_rsvd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q[5:4]) == 2'b10) |-> !irq_req[1]);

    assert_pin3_falling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[3] |-> ($past(sync_prev[3]) && !$past(sync_cur[3])));

    assert_pin3_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[3] |=> !irq_req[3]);

    assert_tmr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cnt_pulse |-> $past(tmr_run));

    assert_tcopy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_run) |-> $stable(tcode_q));
endmodule

bind xint_edge_unit xint_edge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .tmr_run(tmr_run), .tmr_cnt_pulse(tmr_cnt_pulse), .mode_q(mode_q),
    .tcode_q(tcode_q), .sync_cur(sync_cur), .sync_prev(sync_prev)
);

// File: tb/sim_xint_edge_unit.sv
module sim_xint_edge_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [3:0]  pin_in = 4'hF;
    logic        tmr_run = 1'b0;
    logic [3:0]  irq_req;
    logic        tmr_cnt_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xint_edge_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .tmr_run(tmr_run), .irq_req(irq_req), .tmr_cnt_pulse(tmr_cnt_pulse)
    );

    // reference model built from the requirements
    logic [3:0] m_s1, m_s2, m_pr, e_irq;
    logic [7:0] m_reg;
    logic [1:0] m_tc;
    logic       m_pend, e_tp;

    function automatic logic exp_hit(input logic [1:0] code, input logic cur, input logic prv);
        case (code)
            2'b00:   return ~cur & prv;
            2'b01:   return cur & ~prv;
            2'b11:   return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] pin_code(input logic [7:0] r, input int p);
        if (p == 3) return 2'b00;
        return r[2*p+2 +: 2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 4'hF; m_s2 <= 4'hF; m_pr <= 4'hF;
            e_irq <= 4'h0; e_tp <= 1'b0;
            m_reg <= 8'h00; m_tc <= 2'b00; m_pend <= 1'b0;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_pr <= m_s2;
            for (int p = 0; p < 4; p++)
                e_irq[p] <= exp_hit(pin_code(m_reg, p), m_s2[p], m_pr[p]);
            e_tp <= exp_hit(m_tc, m_s2[0], m_pr[0]) & tmr_run;
            if (bus_wr && bus_addr == 16'hFFEC) begin
                m_reg <= {bus_wdata[7:2], 2'b00};
                if (!tmr_run) begin m_tc <= bus_wdata[3:2]; m_pend <= 1'b0; end
                else m_pend <= 1'b1;
            end else if (m_pend && !tmr_run) begin
                m_tc <= m_reg[3:2]; m_pend <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_outputs();
        for (int p = 0; p < 4; p++) begin
            if (p == 3)                              check("R6 pin3", irq_req[p], e_irq[p]);
            else if (pin_code(m_reg, p) == 2'b10)    check("R5 rsvd", irq_req[p], e_irq[p]);
            else                                     check("R4 irq", irq_req[p], e_irq[p]);
        end
        check("R7 R8 tmr", tmr_cnt_pulse, e_tp);
    endtask

    task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic [3:0] pins, input logic run);
        @(negedge clk);
        compare_outputs();
        bus_addr = a; bus_wr = w; bus_wdata = d; pin_in = pins; tmr_run = run;
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        compare_outputs();
        bus_addr = a; bus_wr = 1'b0;
        #1 check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2, R9: reset state, no spurious pulse with pins high
        read_chk("R2 reset value", 16'hFFEC, 8'h00);
        repeat (4) step(16'h0, 1'b0, 8'h00, 4'hF, 1'b0);
        check("R9 no pulse after reset", irq_req, 4'h0);
        // R1, R3: write/read
        step(16'hFFEC, 1'b1, 8'hFF, 4'hF, 1'b0);
        read_chk("R3 low bits zero", 16'hFFEC, 8'hFC);
        step(16'hFFED, 1'b1, 8'h00, 4'hF, 1'b0);
        read_chk("R1 other addr write ignored", 16'hFFEC, 8'hFC);
        read_chk("R1 other addr reads zero", 16'h1234, 8'h00);
        // R4 both edges on pin 0, consecutive transitions
        step(16'hFFEC, 1'b1, 8'h0C, 4'hF, 1'b0);
        step(16'h0, 1'b0, 8'h00, 4'hE, 1'b1);
        step(16'h0, 1'b0, 8'h00, 4'hF, 1'b1);
        repeat (4) step(16'h0, 1'b0, 8'h00, 4'hF, 1'b1);
        // R8: write rise while running, pulse pin0 edges, then stop timer
        step(16'hFFEC, 1'b1, 8'h04, 4'hF, 1'b1);
        step(16'h0, 1'b0, 8'h00, 4'hE, 1'b1);
        repeat (4) step(16'h0, 1'b0, 8'h00, 4'hF, 1'b1);
        step(16'h0, 1'b0, 8'h00, 4'hF, 1'b0);
        step(16'h0, 1'b0, 8'h00, 4'hF, 1'b1);
        step(16'h0, 1'b0, 8'h00, 4'hE, 1'b1);
        repeat (4) step(16'h0, 1'b0, 8'h00, 4'hF, 1'b1);
        // R5 reserved code on all configurable pins
        step(16'hFFEC, 1'b1, 8'hA8, 4'hF, 1'b0);
        step(16'h0, 1'b0, 8'h00, 4'h0, 1'b0);
        repeat (4) step(16'h0, 1'b0, 8'h00, 4'hF, 1'b0);
        // constrained random mix
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] pins;
            logic       w, run;
            logic [7:0] d;
            pins = pin_in ^ (($urandom % 3 == 0) ? 4'($urandom) : 4'h0);
            w    = ($urandom % 8 == 0);
            d    = 8'($urandom);
            run  = ($urandom % 6 == 0) ? ~tmr_run : tmr_run;
            step(($urandom % 5 == 0) ? 16'hFFE0 : 16'hFFEC, w, d, pins, run);
        end
        repeat (4) step(16'h0, 1'b0, 8'h00, pin_in, tmr_run);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule